// File: doc/BRIEF.md
# Programmable-Priority Maskable Interrupt Controller

This block gathers a set of interrupt request lines and presents at most one of them at a time to a processor core. Each source owns an 8-bit control register that holds a pending flag, a mask bit and a 3-bit priority level. A rising edge on a request line latches the pending flag. Masked sources keep their pending state and join arbitration once they are unmasked. The winner is the unmasked pending source with the smallest level value. When levels are equal, the lowest source index wins.

The core reports two status bits: interrupts disabled and non-maskable service active. While either bit is set, nothing is presented and all requests stay pending. On acknowledge, the block clears the granted source's pending flag and pushes its level onto an in-service stack. A service-complete pulse pops that stack. While the stack is not empty, only a strictly higher priority (smaller level value) can pre-empt the current service. The last source, the watchdog overflow, takes part only while a configuration input selects maskable mode.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0 and every control register reads 0x47: not pending, masked, level 7.
- R2: A control register reads as {pending, mask, 3'b000, level[2:0]} at `reg_addr` equal to the source index. A 0-to-1 transition of a request line sets its pending flag. A request held high does not set the flag again.
- R3: Among unmasked pending sources, the one with the smallest level value is presented on `irq_vec`. Level 0 is the highest priority.
- R4: Among sources of equal level, the lowest index is presented.
- R5: A masked source keeps its pending flag and is not presented. Once its mask bit is cleared, it is presented without a new request edge.
- R6: While `cpu_id` or `cpu_np` is 1, `irq_out` is 0 and pending flags are kept. When both return to 0, the best pending source is presented.
- R7: When `irq_ack` is high in a cycle where `irq_out` is 1, the pending flag of the source on `irq_vec` is cleared. `irq_vec` carries the zero-extended source index.
- R8: While a service is open, a source is presented only if its level value is strictly smaller than the level of the innermost open service.
- R9: Each `svc_done` pulse closes the innermost open service. The level of the enclosing service is then restored as the pre-emption threshold.
- R10: While `wdt_maskable` is 0, the last source cannot become pending, by request edge or by register write.
- R11: A register write sets mask from bit 6 and level from bits 2:0. Writing 1 to bit 7 sets pending. Writing 1 to bit 5 clears pending. With both bits 0, pending is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Request lines, one per source |
| wdt_maskable | input | 1 | Enables the last source as a maskable interrupt |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | ADDR_W | Source index of the accessed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cpu_id | input | 1 | Core has interrupts disabled |
| cpu_np | input | 1 | Core is servicing a non-maskable event |
| irq_out | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the presented source |
| irq_ack | input | 1 | Core accepts the presented request |
| svc_done | input | 1 | Core finished the innermost service |

## Verification
The hardest state to reach is a nested service. It needs two open services at different levels, plus pending requests at the same level as each of them. The bench gets there by acknowledging a level-3 source and then raising a level-2 source. It then raises same-level competitors and checks that each stays hidden. Finally it pops the stack one step at a time and watches the threshold move back. Around this, the bench runs an exhaustive sweep over every pair of sources and every pair of levels in an 8-source configuration. The expected winner is computed from the level comparison and the index order.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic pend;
    logic mask;
    lvl_t lvl;
  } src_cfg_t;

  localparam lvl_t LVL_LOWEST = '1;
endpackage

// File: rtl/prio_irq_src.sv
module prio_irq_src
  import prio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  logic     src_en,
  input  logic     wr_en,
  input  logic     wr_set,
  input  logic     wr_clr,
  input  logic     wr_mask,
  input  lvl_t     wr_lvl,
  input  logic     ack_clr,
  output src_cfg_t cfg
);
  logic     req_q;
  logic     rise;
  logic     upd;
  src_cfg_t cfg_q, cfg_d;

  assign rise = src_en & req & ~req_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.mask = wr_mask;
      cfg_d.lvl  = wr_lvl;
      if (wr_set) cfg_d.pend = 1'b1;
      if (wr_clr) cfg_d.pend = 1'b0;
    end
    if (ack_clr) cfg_d.pend = 1'b0;
    if (rise)    cfg_d.pend = 1'b1;
    if (!src_en) cfg_d.pend = 1'b0;
  end

  assign upd = wr_en | ack_clr | rise | (~src_en & cfg_q.pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cfg_q <= '{pend: 1'b0, mask: 1'b1, lvl: LVL_LOWEST};
    end else begin
      req_q <= req;
      if (upd) cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clr && !rise |=> !cfg.pend);

  p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.pend && src_en && !ack_clr && !(wr_en && wr_clr) |=> cfg.pend);

  p_wdt_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> !cfg.pend);
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 40,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  src_cfg_t [N_SRC-1:0] cfg,
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx,
  output lvl_t                 win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = LVL_LOWEST;
    for (int i = 0; i < N_SRC; i++) begin
      if (cfg[i].pend && !cfg[i].mask && (!found || cfg[i].lvl < win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = cfg[i].lvl;
      end
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic busy,
  output lvl_t top_lvl
);
  lvl_t [DEPTH-1:0] mem_q, mem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] top_ptr, nxt_ptr, below_ptr;
  logic             do_pop;
  logic             upd;
  lvl_t             below_lvl;

  assign do_pop    = pop && (cnt_q != '0);
  assign top_ptr   = PTR_W'(cnt_q - 1'b1);
  assign nxt_ptr   = PTR_W'(cnt_q);
  assign below_ptr = PTR_W'(cnt_q - 2'd2);
  assign below_lvl = mem_q[below_ptr];

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (push && do_pop) begin
      mem_d[top_ptr] = push_lvl;
    end else if (push) begin
      mem_d[nxt_ptr] = push_lvl;
      cnt_d          = cnt_q + 1'b1;
    end else if (do_pop) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign upd = push | do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy    = (cnt_q != '0);
  assign top_lvl = mem_q[top_ptr];

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && !do_pop |-> cnt_q < CNT_W'(DEPTH));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && !push && cnt_q >= 2 |=> busy && top_lvl == $past(below_lvl));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC   = 40,
  parameter int ADDR_W  = 6,
  parameter int VEC_W   = 6,
  parameter int WDT_IDX = N_SRC - 1,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int DEPTH  = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              wdt_maskable,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cpu_id,
  input  logic              cpu_np,
  output logic              irq_out,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              svc_done
);
  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  src_cfg_t [N_SRC-1:0] cfg_arr;
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  lvl_t                 win_lvl;
  logic                 stk_busy;
  lvl_t                 stk_top;
  logic                 allow;
  logic                 grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic en_g;
    if (g == WDT_IDX) begin : g_wdt
      assign en_g = wdt_maskable;
    end else begin : g_std
      assign en_g = 1'b1;
    end
    prio_irq_src u_src (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req     (irq_req[g]),
      .src_en  (en_g),
      .wr_en   (reg_wr && (reg_addr == ADDR_W'(g))),
      .wr_set  (reg_wdata[7]),
      .wr_clr  (reg_wdata[5]),
      .wr_mask (reg_wdata[6]),
      .wr_lvl  (reg_wdata[LVL_W-1:0]),
      .ack_clr (grant && (win_idx == IDX_W'(g))),
      .cfg     (cfg_arr[g])
    );
  end

  prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .cfg     (cfg_arr),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  prio_irq_stack #(.DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (grant),
    .push_lvl (win_lvl),
    .pop      (svc_done),
    .busy     (stk_busy),
    .top_lvl  (stk_top)
  );

  assign allow   = !stk_busy || (win_lvl < stk_top);
  assign irq_out = found && allow && !cpu_id && !cpu_np;
  assign grant   = irq_out && irq_ack;
  assign irq_vec = VEC_W'(win_idx);

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_addr == ADDR_W'(i))
        reg_rdata = {cfg_arr[i].pend, cfg_arr[i].mask, 3'b000, cfg_arr[i].lvl};
    end
  end

  p_vec_eligible_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> cfg_arr[win_idx].pend && !cfg_arr[win_idx].mask);

  p_push_level_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant |=> stk_busy && stk_top == $past(win_lvl));

  initial begin
    assert (VEC_W >= IDX_W && (1 << ADDR_W) >= N_SRC)
      else $error("vector or address width too small");
  end
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [N-1:0] irq_req;
  logic       wdt_maskable;
  logic       reg_wr;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cpu_id, cpu_np;
  logic       irq_out;
  logic [5:0] irq_vec;
  logic       irq_ack, svc_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wdt_maskable(wdt_maskable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_id(cpu_id), .cpu_np(cpu_np),
    .irq_out(irq_out), .irq_vec(irq_vec), .irq_ack(irq_ack), .svc_done(svc_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 6'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    irq_req = irq_req | m;
    @(negedge clk);
    irq_req = irq_req & ~m;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); svc_done = 1'b1;
    @(negedge clk); svc_done = 1'b0;
  endtask

  // presented state: 1 + vector when irq_out, else 0
  function automatic int pres();
    return irq_out ? 1 + int'(irq_vec) : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d;
    rst_n = 1'b0; irq_req = '0; wdt_maskable = 1'b1; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; cpu_id = 1'b0; cpu_np = 1'b0;
    irq_ack = 1'b0; svc_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", int'(irq_out), 0);
    for (int i = 0; i < N; i++) begin
      rd(i, d);
      chk("R1 reg", d, 'h47);
    end

    // R2 edge sets pending, held level does not re-set
    @(negedge clk); irq_req[0] = 1'b1;
    @(negedge clk);
    rd(0, d); chk("R2 pend set", d, 'hC7);
    wr(0, 'h67);
    rd(0, d); chk("R11 clear while held", d, 'h47);
    repeat (2) @(negedge clk);
    rd(0, d); chk("R2 no re-set on level", d, 'h47);
    irq_req[0] = 1'b0;
    wr(0, 'hC7);
    rd(0, d); chk("R11 sw set", d, 'hC7);
    wr(0, 'h07);
    rd(0, d); chk("R11 no-op keeps pend", d, 'h87);
    chk("R11 presented", pres(), 1 + 0);
    wr(0, 'h67);
    rd(0, d); chk("R11 cleared", d, 'h47);

    // R3 R4 R7 pair sweep
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        for (int la = 0; la < 8; la++) begin
          for (int lb = 0; lb < 8; lb++) begin
            int w1, w2;
            w1 = (lb < la) ? j : i;
            w2 = (w1 == i) ? j : i;
            wr(i, la); wr(j, lb);
            pulse(N'(1 << i) | N'(1 << j));
            chk((la == lb) ? "R4 tie winner" : "R3 level winner", pres(), 1 + w1);
            ack();
            rd(w1, d); chk("R7 ack clears", d & 'h80, 0);
            done();
            chk("R7 second", pres(), 1 + w2);
            ack(); done();
            chk("R7 idle", pres(), 0);
            wr(i, 'h47); wr(j, 'h47);
          end
        end
      end
    end

    // R5 masked stays pending
    wr(6, 'h41);
    pulse(N'(1 << 6));
    chk("R5 masked hidden", pres(), 0);
    rd(6, d); chk("R5 still pending", d, 'hC1);
    wr(6, 'h01);
    chk("R5 unmask presents", pres(), 1 + 6);
    ack(); done();

    // R6 core status gating
    wr(3, 'h05);
    cpu_id = 1'b1;
    pulse(N'(1 << 3));
    chk("R6 id blocks", pres(), 0);
    rd(3, d); chk("R6 held", d, 'h85);
    @(negedge clk); cpu_id = 1'b0; cpu_np = 1'b1;
    #1; chk("R6 np blocks", pres(), 0);
    @(negedge clk); cpu_np = 1'b0;
    #1; chk("R6 released", pres(), 1 + 3);
    ack(); done();
    wr(3, 'h47);

    // R8 R9 nesting
    wr(1, 'h03); wr(2, 'h03); wr(4, 'h02); wr(5, 'h02);
    pulse(N'(1 << 1));
    chk("R8 first", pres(), 1 + 1);
    ack();
    pulse(N'(1 << 2));
    chk("R8 equal blocked", pres(), 0);
    pulse(N'(1 << 4));
    chk("R8 higher preempts", pres(), 1 + 4);
    ack();
    pulse(N'(1 << 5));
    chk("R8 equal inner blocked", pres(), 0);
    done();
    chk("R9 threshold back to 3", pres(), 1 + 5);
    ack(); done();
    chk("R9 level3 still blocked", pres(), 0);
    done();
    chk("R9 empty presents", pres(), 1 + 2);
    ack(); done();
    chk("R9 idle", pres(), 0);
    for (int k = 1; k < 6; k++) wr(k, 'h47);

    // R10 watchdog source gating
    wdt_maskable = 1'b0;
    wr(N - 1, 'h00);
    pulse(N'(1 << (N - 1)));
    rd(N - 1, d); chk("R10 edge ignored", d, 'h00);
    chk("R10 not presented", pres(), 0);
    wr(N - 1, 'h80);
    rd(N - 1, d); chk("R10 write ignored", d, 'h00);
    @(negedge clk); wdt_maskable = 1'b1;
    pulse(N'(1 << (N - 1)));
    chk("R10 enabled", pres(), 1 + N - 1);
    ack(); done();
    wr(N - 1, 'h47);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule